// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block produces the pin timing of a single memory or I/O transfer on a bus where the same lines carry address and data at different times. A request is taken while the sequencer is idle. It carries the direction, the space (memory or I/O), an upper-byte-lane flag, a 20-bit address, a 2-bit segment code and write data. The block then walks through the states T1, T2, T3, zero or more wait states, and T4. It then returns to idle.

During T1 the low lines carry the address, an address-latch strobe is raised, and the upper lines carry the top address bits. From T2 onward the low lines carry write data. For a read they are released, and the device drives them. The upper lines switch to status bits for the rest of the cycle. Read and write strobes, the byte-high enable and the memory/I/O indicator are generated here. A handshake input from the device stretches the cycle. Read data is captured as T4 is entered and stays on `rdata_o` until the next read.

Top module: `mux_bus_seq`

## Requirements
- R1: Out of reset and whenever idle, `ale_o`=0, `ad_oe_o`=0, `ad_o`=0, `as_o`=0, `rd_no`=1, `wr_no`=1, `bhe_no`=1, `mio_o`=1, `busy_o`=0 and `done_o`=0.
- R2: A request seen in idle on a rising edge makes the next state T1. In T1, `ale_o`=1, `ad_oe_o`=1 and `ad_o` equals address bits 15:0. `ale_o` is high for exactly that one clock.
- R3: In T1, `as_o` carries address bits 19:16 for a memory cycle and is all zero for an I/O cycle.
- R4: From T2 through T4, including wait states, `as_o` holds status bits. Bit 3 is always 0. Bit 2 follows `ien_i`. Bits 1:0 give the segment code: 00 extra, 01 stack, 10 code or none, 11 data.
- R5: `bhe_no` is low in T1 only when the request flags the upper byte lane, and it is high in every other state.
- R6: For a read, `rd_no` is low in T2, T3 and each wait state, and high otherwise. `rd_no` and `wr_no` are never low together.
- R7: For a write, `wr_no` is low from T2 through T4 and `ad_o` carries the write data with `ad_oe_o`=1. For a read, `ad_oe_o`=0 after T1.
- R8: From T1 through T4, `mio_o` is 1 for a memory cycle and 0 for an I/O cycle.
- R9: `ready_i` is sampled on the rising edge that ends T3 and each wait state. Each low sample adds one wait state, so a cycle with n low samples lasts 4+n clocks.
- R10: On the edge entering T4 of a read, the value on `ad_i` is captured. It appears on `rdata_o` and holds until the next read. `done_o` is high in T4 only.
- R11: `req_i` and the request fields are ignored while the sequencer is busy. They change no pin of the cycle in progress and do not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle (taken only when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory |
| req_hi_i | input | 1 | Transfer uses the upper byte lane |
| req_seg_i | input | 2 | Segment code shown in status |
| req_addr_i | input | 20 | Cycle address |
| req_wdata_i | input | 16 | Write data |
| ien_i | input | 1 | Interrupt-enable flag shown in status |
| ready_i | input | 1 | Device handshake, high = transfer complete |
| ad_i | input | 16 | Low lines as seen from the bus (read data) |
| ad_o | output | 16 | Low lines driven value (address or write data) |
| ad_oe_o | output | 1 | Drive enable for the low lines |
| as_o | output | 4 | Upper lines: address in T1, status after |
| ale_o | output | 1 | Address latch strobe |
| bhe_no | output | 1 | Byte-high enable, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| mio_o | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| rdata_o | output | 16 | Captured read data |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | High during T4 |

## Verification
The bench builds the block with its defaults: a 20-bit address, 16 data lines and 4 upper lines. At that size every kind of cycle can be covered. It sweeps all 128 combinations of direction, space, byte-lane flag, segment code and 0 to 3 wait states. In every state it compares each pin with values derived from the request. Half of the cycles hold the request high with altered fields while busy. The read bus carries a decoy value during wait states, so the capture point and the hold of read data are both exposed.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;

  typedef struct packed {
    logic       wr;
    logic       io;
    logic       hi;
    logic [1:0] seg;
  } cyc_kind_t;
endpackage

// File: rtl/mbs_timing.sv
module mbs_timing
  import mbs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = ((state_q == ST_T3) || (state_q == ST_TW)) && ready_i;

  p_min_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_T4) |-> ($past(state_q) == ST_T3 || $past(state_q) == ST_TW));

  p_wait_insert_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_T3 || state_q == ST_TW) && !ready_i) |=> (state_q == ST_TW));

  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q != ST_T1));
endmodule

// File: rtl/mbs_req_hold.sv
module mbs_req_hold
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  cyc_kind_t         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_i,
  output cyc_kind_t         kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  cyc_kind_t         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      kind_q  <= kind_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // read data sampled on the edge that enters T4
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rdata_q <= '0;
    else if (capture_i && !kind_q.wr)  rdata_q <= bus_i;
  end

  assign kind_o  = kind_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

  p_hold_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(addr_q) && $stable(kind_q) && $stable(wdata_q)));

  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_q));
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int UP_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_state_e        state_i,
  input  cyc_kind_t         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ien_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [UP_W-1:0]   as_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              mio_o,
  output logic              busy_o,
  output logic              done_o
);
  logic            in_t1, in_data, in_strobe, active;
  logic [UP_W-1:0] upper_addr, status;

  assign in_t1     = (state_i == ST_T1);
  assign in_data   = (state_i == ST_T2) || (state_i == ST_T3) ||
                     (state_i == ST_TW) || (state_i == ST_T4);
  assign in_strobe = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign active    = in_t1 || in_data;

  assign upper_addr = kind_i.io ? '0 : addr_i[ADDR_W-1:DATA_W];

  // status layout: [3]=0, [2]=interrupt enable, [1:0]=segment code
  always_comb begin
    status      = '0;
    status[1:0] = kind_i.seg;
    status[2]   = ien_i;
  end

  always_comb begin
    if (in_t1)                     ad_o = addr_i[DATA_W-1:0];
    else if (in_data && kind_i.wr) ad_o = wdata_i;
    else                           ad_o = '0;
  end

  assign ad_oe_o = in_t1 || (in_data && kind_i.wr);
  assign as_o    = in_t1 ? upper_addr : (in_data ? status : '0);
  assign ale_o   = in_t1;
  assign bhe_no  = !(in_t1 && kind_i.hi);
  assign rd_no   = !(in_strobe && !kind_i.wr);
  assign wr_no   = !(in_data && kind_i.wr);
  assign mio_o   = active ? !kind_i.io : 1'b1;
  assign busy_o  = active;
  assign done_o  = (state_i == ST_T4);

  p_ale_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);

  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_io_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && !mio_o) |-> (as_o == '0));

  p_status_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ale_o) |-> !as_o[3]);

  p_bhe_t1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bhe_no |-> ale_o);
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int UP_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_io_i,
  input  logic              req_hi_i,
  input  logic [1:0]        req_seg_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ien_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [UP_W-1:0]   as_o,
  output logic              ale_o,
  output logic              bhe_no,
  output logic              rd_no,
  output logic              wr_no,
  output logic              mio_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  bus_state_e        state;
  logic              accept, capture;
  cyc_kind_t         kind_in, kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  assign kind_in = '{wr: req_write_i, io: req_io_i, hi: req_hi_i, seg: req_seg_i};

  mbs_timing i_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ready_i   (ready_i),
    .state_o   (state),
    .accept_o  (accept),
    .capture_o (capture)
  );

  mbs_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .kind_i    (kind_in),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .bus_i     (ad_i),
    .kind_o    (kind_q),
    .addr_o    (addr_q),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_o)
  );

  mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .kind_i  (kind_q),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .ien_i   (ien_i),
    .ad_o    (ad_o),
    .ad_oe_o (ad_oe_o),
    .as_o    (as_o),
    .ale_o   (ale_o),
    .bhe_no  (bhe_no),
    .rd_no   (rd_no),
    .wr_no   (wr_no),
    .mio_o   (mio_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );
endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, req_wr = 0, req_io = 0, req_hi = 0, ien = 0, ready = 0;
  logic [1:0]  req_seg = 0;
  logic [19:0] req_addr = 0;
  logic [15:0] req_wdata = 0, ad_in = 0;
  logic [15:0] ad_out, rdata;
  logic [3:0]  as_out;
  logic        ad_oe, ale, bhe_n, rd_n, wr_n, mio, busy, done;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_write_i(req_wr),
    .req_io_i(req_io), .req_hi_i(req_hi), .req_seg_i(req_seg),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .ien_i(ien),
    .ready_i(ready), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .as_o(as_out), .ale_o(ale), .bhe_no(bhe_n), .rd_no(rd_n), .wr_no(wr_n),
    .mio_o(mio), .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // phase: 0 idle, 1 T1, 2 T2/T3/wait, 3 T4
  task automatic chk_pins(input int ph, input logic wr, input logic io, input logic hi,
                          input logic [1:0] seg, input logic [19:0] a, input logic [15:0] wd);
    logic [15:0] e_ad;
    logic [3:0]  e_as;
    e_ad = (ph == 1) ? a[15:0] : ((ph >= 2 && wr) ? wd : 16'h0);
    if (ph == 1)      e_as = io ? 4'h0 : a[19:16];
    else if (ph >= 2) e_as = {1'b0, ien, seg};
    else              e_as = 4'h0;
    chk("R1 busy",  busy,  ph != 0);
    chk("R2 ale",   ale,   ph == 1);
    chk("R2 R7 ad", ad_out, e_ad);
    chk("R7 ad_oe", ad_oe, (ph == 1) || (ph >= 2 && wr));
    chk(ph == 1 ? "R3 as" : "R4 as", as_out, e_as);
    chk("R5 bhe_n", bhe_n, !(ph == 1 && hi));
    chk("R6 rd_n",  rd_n,  !(ph == 2 && !wr));
    chk("R7 wr_n",  wr_n,  !(ph >= 2 && wr));
    chk("R8 mio",   mio,   (ph == 0) ? 1'b1 : !io);
    chk("R10 done", done,  ph == 3);
  endtask

  task automatic run_cyc(input int idx);
    logic        wr, io, hi, hold;
    logic [1:0]  seg;
    int          waits;
    logic [19:0] a;
    logic [15:0] wd, pat;
    wr    = idx[0];
    io    = idx[1];
    hi    = idx[2];
    seg   = idx[4:3];
    waits = idx[6:5];
    hold  = idx[2] ^ idx[5];
    a     = 20'h5A3C1 ^ (20'(idx) * 20'h1357B);
    wd    = 16'hC0DE ^ (16'(idx) * 16'h0F1D);
    pat   = {idx[7:0], ~idx[7:0]} ^ 16'h3C5A;

    @(negedge clk);
    req = 1; req_wr = wr; req_io = io; req_hi = hi; req_seg = seg;
    req_addr = a; req_wdata = wd; ien = idx[0] ^ idx[3]; ready = 0; ad_in = ~pat;
    @(negedge clk);
    chk_pins(1, wr, io, hi, seg, a, wd);
    // R11: request kept high with altered fields during the cycle
    req = hold;
    if (hold) begin
      req_wr = ~wr; req_io = ~io; req_hi = ~hi; req_seg = ~seg;
      req_addr = ~a; req_wdata = ~wd;
    end
    @(negedge clk);
    chk_pins(2, wr, io, hi, seg, a, wd);            // T2
    @(negedge clk);
    chk_pins(2, wr, io, hi, seg, a, wd);            // T3
    ready = (waits == 0);
    ad_in = (waits == 0) ? pat : ~pat;
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      chk_pins(2, wr, io, hi, seg, a, wd);          // R9 wait state
      ready = (k == waits - 1);
      ad_in = (k == waits - 1) ? pat : ~pat;
    end
    @(negedge clk);
    chk_pins(3, wr, io, hi, seg, a, wd);            // R9 T4 after 4+waits clocks
    if (!wr) chk("R10 rdata", rdata, pat);
    req = 0; ready = 0; ad_in = ~pat;
    @(negedge clk);
    chk_pins(0, wr, io, hi, seg, a, wd);
    if (!wr) chk("R10 rdata hold", rdata, pat);
    @(negedge clk);
    chk("R11 no restart", busy, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_pins(0, 1'b0, 1'b0, 1'b0, 2'b00, 20'h0, 16'h0);   // R1 in reset
    rst_n = 1;
    @(negedge clk);
    chk_pins(0, 1'b0, 1'b0, 1'b0, 2'b00, 20'h0, 16'h0);   // R1 after reset
    chk("R1 rdata", rdata, 16'h0);
    for (int i = 0; i < 128; i++) run_cyc(i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule